// File: doc/BRIEF.md
# Gated Rate and Live-Time Scaler Bank

This block is a bank of event-rate scalers whose counting is limited to one measurement window of fixed length. A pulser with a known rate (nominally 1 kHz) drives a preset counter. A start command opens the window. The window closes by itself after a preset number of pulser ticks (nominally 10000, about 10 s). Every channel scaler counts rising edges on its own event input, but only while the window is open.

Two more counters are formed from the pulser. The elapsed counter counts every pulser tick inside the window. The live counter counts only the ticks that arrive while the readout busy input is low. Their ratio gives the live fraction, which is the denominator needed to turn raw counts into absolute rates.

Software reads the results through a simple registered read port, addressed by counter index. A done flag reports that the window has closed and stays set until the next start command.

Top module: `rate_scaler_bank`

## Requirements
- R1: After reset every counter reads zero, `win_open_o` is 0 and `win_done_o` is 0.
- R2: A cycle with `start_i` high clears every counter, sets `win_open_o` and clears `win_done_o`, all at the same clock edge. Any count that arrives at that edge is discarded. This holds even while a window is already open.
- R3: Each channel counter advances by exactly one for each rising edge on its event input while the window is open, whatever the pulse width. Inputs pass through a two-stage synchronizer before edge detection.
- R4: No channel, elapsed or live counter changes while the window is closed. This covers both before the first start and after the window has ended.
- R5: The window closes on the PRESET_COUNT-th pulser rising edge after start. On that edge `win_open_o` falls and `win_done_o` rises.
- R6: The elapsed counter counts every pulser rising edge that occurs while the window is open.
- R7: The live counter counts pulser rising edges inside the window only when the synchronized busy input is low. It never exceeds the elapsed counter.
- R8: Every counter saturates at all-ones (2^CNT_W-1) instead of wrapping.
- R9: `win_done_o` stays high until the next start command.
- R10: The read port is registered, so `rd_data_o` shows the selected counter one cycle after `rd_addr_i` is applied. Addresses 0 to N_CH-1 select the channel counters. Address N_CH selects the elapsed counter and N_CH+1 the live counter. Any higher address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clear all counters and open a new window |
| pulser_i | input | 1 | Asynchronous timing pulser |
| busy_i | input | 1 | Asynchronous readout busy level |
| evt_i | input | N_CH | Asynchronous event pulses, one per channel |
| rd_addr_i | input | $clog2(N_CH+2) | Counter select for the read port |
| rd_data_o | output | CNT_W | Selected counter value, registered |
| win_open_o | output | 1 | Measurement window is open |
| win_done_o | output | 1 | Window has ended since the last start |

## Verification
The bench uses a small configuration in which the preset exceeds the counter range. With that setup the elapsed counter saturates before the window closes, which exposes a design that wraps to zero or that ties closure to the elapsed counter. Every channel receives a different number of pulses, each of a different width. A design that counts levels or misses short pulses therefore gives wrong per-channel totals.

Busy follows a modular pattern across the ticks. A wrongly gated live counter then lands on a count different from the computed one.

Further checks cover the following cases:
- Pulses and ticks are sent after the window closes. A leaky gate would move the counts, and a done flag that is not held would drop.
- A start is issued in the middle of a window. A design that fails to clear would keep stale counts.
- An out-of-range read is made. A design that does not return zero for it would echo a counter.

// File: rtl/rsb_pkg.sv
// Package: shared types for the rate scaler bank.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package rsb_pkg;

    // State of the measurement window as seen by the rest of the bank.
    typedef struct packed {
        logic open;
        logic done;
    } win_state_t;

    // Saturating increment: returns val+1, or val when val is already all-ones.
    function automatic logic [63:0] sat_inc(input logic [63:0] val, input int unsigned width);
        logic [63:0] lim;
        lim = (width >= 64) ? {64{1'b1}} : ((64'd1 << width) - 64'd1);
        return (val >= lim) ? lim : val + 64'd1;
    endfunction

endpackage

// File: rtl/rsb_sync.sv
// Module: rsb_sync
// Two-flop synchronizer for W asynchronous inputs. RISE=1 gives one-cycle
// pulses on each synchronized rising edge; RISE=0 gives the synchronized level.
// Assumes each input stays stable for at least one clock period per level.
module rsb_sync #(
    parameter int W    = 1,
    parameter bit RISE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    generate
        if (RISE) begin : g_edge
            logic [W-1:0] last_q;

            // Previous synchronized level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= '0;
                else        last_q <= sync_q;
            end

            assign q_o = sync_q & ~last_q;

            // R3: an edge pulse never lasts two cycles on the same bit.
            p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o != '0) |=> ((q_o & $past(q_o)) == '0));
        end else begin : g_level
            assign q_o = sync_q;
        end
    endgenerate

endmodule

// File: rtl/rsb_window.sv
// Module: rsb_window
// Preset counter that defines the measurement window. Start clears it and opens
// the window. Each pulser tick while open advances it, and the PRESET_COUNT-th
// tick closes the window and raises done, which holds until the next start.
// Assumes tick_i is a one-cycle pulse and PRESET_COUNT >= 1.
module rsb_window
    import rsb_pkg::*;
#(
    parameter int PRESET_COUNT = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tick_i,
    output win_state_t win_o
);

    localparam int PW = $clog2(PRESET_COUNT + 1);
    localparam logic [PW-1:0] LAST = PW'(PRESET_COUNT - 1);

    logic [PW-1:0] ticks_q;
    win_state_t    st_q;

    // Preset tick counter and window open/done state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '0;
            st_q    <= '0;
        end else if (start_i) begin
            ticks_q <= '0;
            st_q    <= '{open: 1'b1, done: 1'b0};
        end else if (st_q.open && tick_i) begin
            ticks_q <= ticks_q + PW'(1);
            if (ticks_q == LAST) begin
                st_q <= '{open: 1'b0, done: 1'b1};
            end
        end
    end

    assign win_o = st_q;

    // R5: the window is never open and done at once.
    p_open_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.open && st_q.done));

    // R2: a start always leaves the window open and not done.
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.open && !st_q.done));

    // R9: done holds until a start arrives.
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !start_i) |=> st_q.done);

    // R5: the window cannot close without a tick.
    p_close_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && !tick_i && !start_i) |=> st_q.open);

endmodule

// File: rtl/rsb_counter.sv
// Module: rsb_counter
// W-bit counter with synchronous clear and saturation at all-ones.
// Assumes clr_i takes priority over inc_i in the same cycle.
module rsb_counter
    import rsb_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    // Clear, saturating increment, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (inc_i)  cnt_q <= W'(sat_inc(64'(cnt_q), W));
    end

    assign cnt_o = cnt_q;

    // R8: without a clear the value never falls (no wrap).
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q >= $past(cnt_q)));

    // R3: a counter moves by at most one per cycle.
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/rate_scaler_bank.sv
// Module: rate_scaler_bank (top)
// A bank of N_CH gated event scalers plus elapsed and live pulser counters, all
// counting only inside a window set by a pulser-driven preset counter. Results
// are read through a registered address/data port.
// Assumes start_i is synchronous to clk; all other inputs may be asynchronous.
module rate_scaler_bank
    import rsb_pkg::*;
#(
    parameter int N_CH         = 12,
    parameter int CNT_W        = 24,
    parameter int PRESET_COUNT = 10000,
    localparam int AW          = $clog2(N_CH + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            pulser_i,
    input  logic            busy_i,
    input  logic [N_CH-1:0] evt_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic            win_open_o,
    output logic            win_done_o
);

    localparam int ADDR_RUN  = N_CH;
    localparam int ADDR_LIVE = N_CH + 1;

    logic [N_CH-1:0]  evt_rise;
    logic             tick;
    logic             busy_s;
    win_state_t       win;
    logic [CNT_W-1:0] ch_cnt [N_CH];
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] rd_q;

    rsb_sync #(.W(N_CH), .RISE(1'b1)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .d_i(evt_i), .q_o(evt_rise)
    );

    rsb_sync #(.W(1), .RISE(1'b1)) u_pulser_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pulser_i), .q_o(tick)
    );

    rsb_sync #(.W(1), .RISE(1'b0)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d_i(busy_i), .q_o(busy_s)
    );

    rsb_window #(.PRESET_COUNT(PRESET_COUNT)) u_window (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick), .win_o(win)
    );

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            rsb_counter #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr_i(start_i),
                .inc_i(win.open && evt_rise[i]), .cnt_o(ch_cnt[i])
            );

            // R4: a closed window freezes every channel counter.
            p_closed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!win.open && !start_i) |=> $stable(ch_cnt[i]));
        end
    endgenerate

    rsb_counter #(.W(CNT_W)) u_run_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .inc_i(win.open && tick), .cnt_o(run_cnt)
    );

    rsb_counter #(.W(CNT_W)) u_live_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .inc_i(win.open && tick && !busy_s), .cnt_o(live_cnt)
    );

    // Registered read multiplexer over channel, elapsed and live counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (int'(rd_addr_i) < N_CH) begin
            rd_q <= ch_cnt[rd_addr_i];
        end else if (int'(rd_addr_i) == ADDR_RUN) begin
            rd_q <= run_cnt;
        end else if (int'(rd_addr_i) == ADDR_LIVE) begin
            rd_q <= live_cnt;
        end else begin
            rd_q <= '0;
        end
    end

    assign rd_data_o  = rd_q;
    assign win_open_o = win.open;
    assign win_done_o = win.done;

    // R7: live time never exceeds elapsed time.
    p_live_le_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt <= run_cnt);

    // R4: elapsed and live counters are frozen while closed.
    p_closed_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!win.open && !start_i) |=> ($stable(run_cnt) && $stable(live_cnt)));

    // R10: out-of-range addresses read zero.
    p_rd_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr_i) > ADDR_LIVE) |=> (rd_q == '0));

endmodule

// File: tb/rate_scaler_bank_bench.sv
`timescale 1ns/1ps
module rate_scaler_bank_bench;

    localparam int N_CH   = 4;
    localparam int CNT_W  = 5;
    localparam int PRESET = 40;
    localparam int AW     = $clog2(N_CH + 2);
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic pulser_i = 1'b0;
    logic busy_i = 1'b0;
    logic [N_CH-1:0] evt_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [CNT_W-1:0] rd_data_o;
    logic win_open_o;
    logic win_done_o;

    int n_checks = 0;
    int n_fail = 0;
    int exp_live;

    always #2 clk = ~clk;

    rate_scaler_bank #(.N_CH(N_CH), .CNT_W(CNT_W), .PRESET_COUNT(PRESET)) u_rate_scaler_bank (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pulser_i(pulser_i),
        .busy_i(busy_i), .evt_i(evt_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .win_open_o(win_open_o), .win_done_o(win_done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output int val);
        @(negedge clk) rd_addr_i = AW'(addr);
        @(negedge clk) val = int'(rd_data_o);
    endtask

    task automatic chk_rd(input string req, input int addr, input int exp);
        int v;
        rd(addr, v);
        chk(req, v, exp);
    endtask

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse(input int ch, input int width);
        @(negedge clk) evt_i[ch] = 1'b1;
        repeat (width) @(negedge clk);
        evt_i[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic tick(input logic b);
        @(negedge clk) busy_i = b;
        repeat (4) @(negedge clk);
        pulser_i = 1'b1;
        repeat (2) @(negedge clk);
        pulser_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk("R1 open", int'(win_open_o), 0);
        chk("R1 done", int'(win_done_o), 0);
        for (int a = 0; a < N_CH + 2; a++) chk_rd("R1 counter", a, 0);

        // R4: nothing counts before the first start
        pulse(0, 2);
        tick(1'b0);
        chk_rd("R4 pre-start ch0", 0, 0);
        chk_rd("R4 pre-start elapsed", N_CH, 0);

        // R2: restart mid-window discards counts
        do_start();
        chk("R2 open", int'(win_open_o), 1);
        pulse(0, 1); pulse(0, 1);
        chk_rd("R3 ch0 two", 0, 2);
        do_start();
        chk_rd("R2 restart ch0", 0, 0);

        // R3: channel ch gets 2*ch+1 pulses of widths 1..
        for (int ch = 0; ch < N_CH; ch++)
            for (int n = 0; n < 2 * ch + 1; n++) pulse(ch, (n % 5) + 1);
        repeat (4) @(negedge clk);
        for (int ch = 0; ch < N_CH; ch++) chk_rd("R3 channel count", ch, 2 * ch + 1);

        // R6/R7/R5/R8: ticks with busy on every third
        exp_live = 0;
        for (int k = 0; k < PRESET - 1; k++) begin
            tick((k % 3) == 0);
            if ((k % 3) != 0) exp_live++;
            if (k == 9) chk_rd("R6 elapsed after 10", N_CH, 10);
        end
        chk("R5 still open", int'(win_open_o), 1);
        chk("R5 not done", int'(win_done_o), 0);
        chk_rd("R8 elapsed saturated", N_CH, MAXV);
        chk_rd("R7 live", N_CH + 1, exp_live);
        tick(1'b0);
        exp_live++;
        chk("R5 closed", int'(win_open_o), 0);
        chk("R5 done", int'(win_done_o), 1);
        chk_rd("R7 live final", N_CH + 1, exp_live);

        // R4/R9: no counting and done held after close
        pulse(1, 2);
        tick(1'b0);
        tick(1'b0);
        repeat (4) @(negedge clk);
        chk_rd("R4 post ch1", 1, 3);
        chk_rd("R4 post live", N_CH + 1, exp_live);
        chk("R9 done held", int'(win_done_o), 1);

        // R10: out-of-range addresses read zero
        for (int a = N_CH + 2; a < (1 << AW); a++) chk_rd("R10 oob", a, 0);

        // R2/R8: new window, saturation sweep on channels
        do_start();
        chk("R2 done cleared", int'(win_done_o), 0);
        chk_rd("R2 live cleared", N_CH + 1, 0);
        for (int n = 0; n < MAXV + 4; n++) pulse(0, 1);
        for (int n = 0; n < MAXV; n++) pulse(1, 2);
        for (int n = 0; n < MAXV - 1; n++) pulse(2, 1);
        repeat (4) @(negedge clk);
        chk_rd("R8 ch0 saturated", 0, MAXV);
        chk_rd("R8 ch1 at max", 1, MAXV);
        chk_rd("R8 ch2 below max", 2, MAXV - 1);
        chk_rd("R3 ch3 idle", 3, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule